// File: doc/BRIEF.md
# Programmable Frequency Generator Bank

The block holds six frequency generators that each count strobes from a chosen source and emit a one-cycle tick once every N strobes. Everything runs on one fast reference clock. The sources arrive as single-cycle strobe inputs and the outputs are single-cycle ticks, so no clock is gated or divided directly. Software configures the bank through two 32-bit control words. Each word holds three 10-bit generator fields, and a plain write port and a combinational readback port give access to the words.

A `MODE` parameter picks one of two variants. The legacy variant has two sources, a separate enable bit and even divide ratios from 2 to 512. The extended variant has three sources and uses mux code zero to mean off. It also adds a per-word scale bit that allows any ratio from 1 to 256.

Top module: `fgen_bank`

## Requirements
- R1: Word 0 holds generators 0, 1 and 2 and word 1 holds generators 3, 4 and 5. Each generator has a 10-bit field at bit offset 0, 10 or 20, and within a field bits 9:2 carry the divisor code D. A write with `wr_en` high stores `wr_data` into the word chosen by `wr_sel`.
- R2: `rd_data` always returns exactly the last value written to the word chosen by `rd_sel`, including bits 31 and 30.
- R3: In legacy mode (`MODE`=0), field bit 0 selects the source (0 selects `src_stb[0]`, 1 selects `src_stb[1]`) and field bit 1 enables the generator. The ratio is (D+1)*2. Word bit 30 and `src_stb[2]` have no effect on any output.
- R4: In extended mode (`MODE`=1), field bits 1:0 are a mux code. Codes 1, 2 and 3 select `src_stb[0]`, `src_stb[1]` and `src_stb[2]`, and code 0 disables the generator. A generator is enabled exactly when its code is non-zero.
- R5: In extended mode, bit 30 of a word is a scale bit for its three generators. When the bit is set the ratio is D+1; when it is clear the ratio is (D+1)*2.
- R6: An enabled generator with ratio N raises its tick for one cycle, in the cycle after the strobe that completes each group of N strobes from its selected source. Strobes from other sources are not counted.
- R7: A change to the source or divisor made in the middle of a period does not affect that period. The period finishes with the settings that were in force at its first strobe, and the new settings apply from the next period.
- R8: A disabled generator keeps its tick low and clears its strobe count. When it is enabled again, it starts a full new period.
- R9: After reset both words read as zero and all ticks are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for a control word |
| wr_sel | input | 1 | Control word selected for a write |
| wr_data | input | 32 | Data to write |
| rd_sel | input | 1 | Control word selected for readback |
| rd_data | output | 32 | Readback of the selected control word |
| src_stb | input | 3 | One strobe input per source |
| tick_out | output | 6 | One tick output per generator |

## Verification
The bench builds two instances side by side: one with `MODE`=1 (extended) and one with `MODE`=0 (legacy), both with the default packing of three generators per word. The extended instance can reach ratio 1, odd ratios, the maximum ratios 256 and 512, the scale bit and the third source. The legacy instance shows that its separate enable bit is honoured and that the scale bit and third source are ignored. Strobe runs of over a thousand cycles cover full wraps at the largest ratios. Directed runs rewrite a field or disable a generator in the middle of a period.

// File: rtl/fgen_pkg.sv
package fgen_pkg;

    localparam int FIELD_W   = 10;
    localparam int DIV_W     = 8;
    localparam int RATIO_W   = DIV_W + 2;
    localparam int SRC_IDX_W = 2;

    typedef struct packed {
        logic                 en;
        logic [SRC_IDX_W-1:0] src;
        logic [RATIO_W-1:0]   ratio;
    } gen_cfg_t;

    // Turn one packed generator field into an enable, source index and ratio.
    function automatic gen_cfg_t decode_field(input logic ext,
                                              input logic [FIELD_W-1:0] fld,
                                              input logic scale);
        gen_cfg_t           c;
        logic [RATIO_W-1:0] base;
        base = RATIO_W'(fld[FIELD_W-1:2]) + RATIO_W'(1);
        if (ext) begin
            c.en    = (fld[1:0] != 2'd0);
            c.src   = fld[1:0] - 2'd1;
            c.ratio = scale ? base : (base << 1);
        end else begin
            c.en    = fld[1];
            c.src   = {1'b0, fld[0]};
            c.ratio = base << 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/fgen_regs.sv
module fgen_regs #(
    parameter int NUM_REGS = 2,
    parameter int REG_W    = 32,
    parameter int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [SEL_W-1:0]                 wr_sel,
    input  logic [REG_W-1:0]                 wr_data,
    output logic [NUM_REGS-1:0][REG_W-1:0]   ctl_q
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q[r] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(r))) begin
                ctl_q[r] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/fgen_div.sv
module fgen_div
    import fgen_pkg::*;
#(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  gen_cfg_t           cfg_live,
    input  logic [NUM_SRC-1:0] src_stb,
    output logic               tick
);

    gen_cfg_t           cfg_act;
    gen_cfg_t           cur;
    logic [RATIO_W-1:0] cnt;
    logic               stb;
    logic               last;

    // At the start of a period the live field applies; afterwards the captured one.
    always_comb begin
        cur = (cnt == '0) ? cfg_live : cfg_act;
        stb = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cur.src == SRC_IDX_W'(i)) begin
                stb = src_stb[i];
            end
        end
        last = (cnt == (cur.ratio - RATIO_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            tick    <= 1'b0;
            cfg_act <= '0;
        end else if (!cfg_live.en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (stb) begin
            if (cnt == '0) begin
                cfg_act <= cfg_live;
            end
            if (last) begin
                cnt  <= '0;
                tick <= 1'b1;
            end else begin
                cnt  <= cnt + RATIO_W'(1);
                tick <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/fgen_bank.sv
module fgen_bank
    import fgen_pkg::*;
#(
    parameter int MODE        = 1,
    parameter int NUM_REGS    = 2,
    parameter int GEN_PER_REG = 3,
    parameter int REG_W       = 32,
    parameter int SCALE_BIT   = 30,
    parameter int NUM_SRC     = 3,
    parameter int SEL_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    parameter int NUM_GEN     = NUM_REGS * GEN_PER_REG
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [REG_W-1:0]   rd_data,
    input  logic [NUM_SRC-1:0] src_stb,
    output logic [NUM_GEN-1:0] tick_out
);

    localparam logic IS_EXT = (MODE != 0);

    logic [NUM_REGS-1:0][REG_W-1:0] ctl_q;

    fgen_regs #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .SEL_W    (SEL_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctl_q   (ctl_q)
    );

    assign rd_data = ctl_q[rd_sel];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar g = 0; g < GEN_PER_REG; g++) begin : g_gen
            gen_cfg_t cfg;
            assign cfg = decode_field(IS_EXT,
                                      ctl_q[r][g*FIELD_W +: FIELD_W],
                                      ctl_q[r][SCALE_BIT]);
            fgen_div #(
                .NUM_SRC (NUM_SRC)
            ) u_div (
                .clk      (clk),
                .rst      (rst),
                .cfg_live (cfg),
                .src_stb  (src_stb),
                .tick     (tick_out[r*GEN_PER_REG + g])
            );
        end
    end

endmodule

// File: rtl/fgen_bank_chk.sv
module fgen_bank_chk #(
    parameter int MODE        = 1,
    parameter int NUM_REGS    = 2,
    parameter int GEN_PER_REG = 3,
    parameter int REG_W       = 32,
    parameter int NUM_SRC     = 3,
    parameter int SEL_W       = 1,
    parameter int NUM_GEN     = NUM_REGS * GEN_PER_REG
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           wr_en,
    input logic [SEL_W-1:0]               wr_sel,
    input logic [REG_W-1:0]               wr_data,
    input logic [NUM_REGS-1:0][REG_W-1:0] ctl_q,
    input logic [NUM_SRC-1:0]             src_stb,
    input logic [NUM_GEN-1:0]             tick_out
);

    localparam int FW = 10;

    assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctl_q[$past(wr_sel)] == $past(wr_data)));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_r
        for (genvar g = 0; g < GEN_PER_REG; g++) begin : g_g
            logic on;
            if (MODE != 0) begin : g_ext
                assign on = (ctl_q[r][g*FW +: 2] != 2'd0);
            end else begin : g_leg
                assign on = ctl_q[r][g*FW + 1];
            end

            assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
                !on |=> !tick_out[r*GEN_PER_REG + g]);

            assert_tick_needs_strobe_R6: assert property (@(posedge clk) disable iff (rst)
                tick_out[r*GEN_PER_REG + g] |-> $past(|src_stb));

            if (MODE == 0) begin : g_min2
                assert_legacy_min_ratio_R3: assert property (@(posedge clk) disable iff (rst)
                    tick_out[r*GEN_PER_REG + g] |=> !tick_out[r*GEN_PER_REG + g]);
            end
        end
    end

endmodule

bind fgen_bank fgen_bank_chk #(
    .MODE        (MODE),
    .NUM_REGS    (NUM_REGS),
    .GEN_PER_REG (GEN_PER_REG),
    .REG_W       (REG_W),
    .NUM_SRC     (NUM_SRC),
    .SEL_W       (SEL_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .ctl_q    (ctl_q),
    .src_stb  (src_stb),
    .tick_out (tick_out)
);

// File: tb/fgen_bank_tb.sv
module fgen_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  src_stb = '0;
    logic        wx_en = 1'b0, wl_en = 1'b0;
    logic        wx_sel = 1'b0, wl_sel = 1'b0;
    logic [31:0] wx_data = '0, wl_data = '0;
    logic        rx_sel = 1'b0, rl_sel = 1'b0;
    logic [31:0] rx_data, rl_data;
    logic [5:0]  tx, tl;

    int checks = 0;
    int failures = 0;
    int cx [6];
    int cl [6];

    always #10 clk = ~clk;

    fgen_bank #(.MODE(1)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wx_en), .wr_sel(wx_sel), .wr_data(wx_data),
        .rd_sel(rx_sel), .rd_data(rx_data), .src_stb(src_stb), .tick_out(tx));

    fgen_bank #(.MODE(0)) dut_leg_i (
        .clk(clk), .rst(rst), .wr_en(wl_en), .wr_sel(wl_sel), .wr_data(wl_data),
        .rd_sel(rl_sel), .rd_data(rl_data), .src_stb(src_stb), .tick_out(tl));

    initial begin
        for (int g = 0; g < 6; g++) begin
            cx[g] = 0;
            cl[g] = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            for (int g = 0; g < 6; g++) begin
                cx[g] = cx[g] + int'(tx[g]);
                cl[g] = cl[g] + int'(tl[g]);
            end
        end
    end

    typedef struct packed {
        logic [31:0] r0;
        logic [31:0] r1;
        logic [2:0]  mask;
        logic [15:0] len;
        logic [95:0] expd;
    } vec_t;

    // Extended-mode vectors; expected tick counts packed {g5,g4,g3,g2,g1,g0}.
    localparam vec_t VECS [3] = '{
        '{32'h4130_2801, 32'h00E0_3001, 3'b111, 16'd40,
          {16'd5, 16'd0, 16'd20, 16'd8, 16'd13, 16'd40}},
        '{32'h4130_2801, 32'h00E0_3001, 3'b001, 16'd30,
          {16'd0, 16'd0, 16'd15, 16'd0, 16'd0, 16'd30}},
        '{32'h01C0_17FF, 32'h4020_9FFD, 3'b101, 16'd1030,
          {16'd0, 16'd103, 16'd4, 16'd0, 16'd257, 16'd2}}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_x(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wx_en = 1'b1; wx_sel = sel; wx_data = d;
        @(negedge clk);
        wx_en = 1'b0;
    endtask

    task automatic wr_l(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wl_en = 1'b1; wl_sel = sel; wl_data = d;
        @(negedge clk);
        wl_en = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] mask, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_stb = mask;
        end
        @(negedge clk);
        src_stb = '0;
        repeat (3) @(negedge clk);
    endtask

    int bx [6];
    int bl [6];

    task automatic snap();
        for (int g = 0; g < 6; g++) begin
            bx[g] = cx[g];
            bl[g] = cl[g];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        rx_sel = 1'b0; rl_sel = 1'b1;
        #1;
        check("R9 ext word0", rx_data, 32'h0);
        check("R9 leg word1", rl_data, 32'h0);
        check("R9 ticks", {26'h0, tx}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        rx_sel = 1'b1; rl_sel = 1'b0;
        #1;
        check("R9 ext word1", rx_data, 32'h0);
        check("R9 leg word0", rl_data, 32'h0);

        // R1 R4 R5 R6: extended vector table
        for (int v = 0; v < 3; v++) begin
            wr_x(1'b0, 32'h0);
            wr_x(1'b1, 32'h0);
            wr_x(1'b0, VECS[v].r0);
            wr_x(1'b1, VECS[v].r1);
            snap();
            pulse(VECS[v].mask, int'(VECS[v].len));
            for (int g = 0; g < 6; g++) begin
                check($sformatf("R6 R5 R4 R1 vec%0d gen%0d", v, g),
                      32'(cx[g] - bx[g]), 32'(VECS[v].expd[g*16 +: 16]));
            end
        end

        // R2: exact readback
        wr_x(1'b1, 32'hC123_4567);
        rx_sel = 1'b1; #1;
        check("R2 ext readback", rx_data, 32'hC123_4567);

        // R3: legacy field, bit 30 ignored, bit 31 kept
        wr_l(1'b0, 32'h8000_2C02);
        wr_l(1'b1, 32'h4030_1BFF);
        rl_sel = 1'b0; #1;
        check("R2 leg readback word0", rl_data, 32'h8000_2C02);
        rl_sel = 1'b1; #1;
        check("R2 leg readback word1", rl_data, 32'h4030_1BFF);
        snap();
        pulse(3'b011, 60);
        check("R3 leg gen0 ratio2",  32'(cl[0] - bl[0]), 32'd30);
        check("R3 leg gen1 ratio6",  32'(cl[1] - bl[1]), 32'd10);
        check("R3 leg gen2 off",     32'(cl[2] - bl[2]), 32'd0);
        check("R3 leg gen3 ratio512", 32'(cl[3] - bl[3]), 32'd0);
        check("R3 leg gen4 ratio4",  32'(cl[4] - bl[4]), 32'd15);
        check("R3 leg gen5 scale ignored", 32'(cl[5] - bl[5]), 32'd30);
        snap();
        pulse(3'b100, 20);
        for (int g = 0; g < 6; g++) begin
            check($sformatf("R3 leg src2 ignored gen%0d", g), 32'(cl[g] - bl[g]), 32'd0);
        end

        // R7: divisor rewrite mid-period (ratio 4 -> 2)
        wr_x(1'b1, 32'h0);
        wr_x(1'b0, 32'h0);
        wr_x(1'b0, 32'h0000_0005);
        snap();
        pulse(3'b001, 2);
        wr_x(1'b0, 32'h0000_0001);
        pulse(3'b001, 2);
        check("R7 old ratio finishes period", 32'(cx[0] - bx[0]), 32'd1);
        snap();
        pulse(3'b001, 4);
        check("R7 new ratio next period", 32'(cx[0] - bx[0]), 32'd2);

        // R8: disable mid-period restarts the count
        wr_x(1'b0, 32'h0);
        wr_x(1'b0, 32'h0000_0005);
        snap();
        pulse(3'b001, 3);
        wr_x(1'b0, 32'h0);
        @(negedge clk);
        check("R8 disabled tick low", {31'h0, tx[0]}, 32'h0);
        wr_x(1'b0, 32'h0000_0005);
        pulse(3'b001, 3);
        check("R8 fresh period no tick", 32'(cx[0] - bx[0]), 32'd0);
        pulse(3'b001, 1);
        check("R8 fresh period completes", 32'(cx[0] - bx[0]), 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule